// File: doc/BRIEF.md
# Register-Mapped Flash Command Controller

This block emulates a pair of nonvolatile byte arrays behind a small register window of seven byte-wide registers. Software loads up to four data bytes and a 16-bit address, then writes a command code. The controller carries out a read, program, erase or verify on the selected array, one byte per clock.

The arrays behave like flash. Erase forces bytes to all ones. Programming can only clear bits, so the stored byte becomes the old byte ANDed with the new one. The data array holds 4 KB arranged as four-byte pages. A second array, the program array, has 64-byte erase blocks. Two mode commands switch the same command codes between the two arrays.

A verify command compares the data registers against a page and leaves its verdict in the command register. A busy output covers every command. Register writes that arrive while busy are dropped. The program array is also visible through a fetch read port, so its contents can be observed from outside the block.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0x01, the data and address registers read 0x00, busy and prog_mode are low, and every byte of both arrays reads 0xFF.
- R2: Register window offsets: 0 to 3 are data registers 1 to 4, 4 is address low, 5 is address high, 6 is the command register. Writes to 0 to 5 read back unchanged, and offset 7 reads 0x00.
- R3: In data mode, code 0x82 replaces the byte at address bits [11:0] with the old byte ANDed with data register 1. Busy lasts 1 cycle.
- R4: In data mode, code 0x81 loads the byte at address bits [11:0] into data register 1. Busy lasts 1 cycle.
- R5: In data mode, code 0x02 programs the page selected by address bits [9:0]. The upper address bits are ignored. The byte at page*4+k becomes the old byte ANDed with data register k+1, for k = 0 to 3. Busy lasts 4 cycles.
- R6: In data mode, code 0x01 loads the bytes at page*4+0 to page*4+3 into data registers 1 to 4. Busy lasts 4 cycles.
- R7: In data mode, code 0x04 compares data registers 1 to 4 with the addressed page. Afterwards the command register reads 0x00 on a full match and 0xFF otherwise. The array is left unchanged, and busy lasts 4 cycles.
- R8: In data mode, code 0x05 sets the four bytes of the addressed page to 0xFF with busy for 4 cycles. Code 0x06 sets all 4096 bytes to 0xFF with busy for 4096 cycles.
- R9: Code 0xF0 raises prog_mode and code 0x0F lowers it, each with busy for 1 cycle. prog_mode selects which array all other codes act on.
- R10: In program mode, code 0x82 ANDs data register 1 into the program-array byte at the full 16-bit address when that address is below the array size. At any larger address nothing changes. Busy lasts 1 cycle. fetch_data returns that byte for fetch_addr, or 0xFF for an address beyond the array.
- R11: In program mode, code 0x05 sets the 64 bytes from (address AND 0xFFC0) upward to 0xFF, with busy for 64 cycles. If the address is beyond the array it changes nothing, with busy for 1 cycle. Code 0x06 sets the whole program array to 0xFF, with busy for as many cycles as the array has bytes.
- R12: Code 0x03, any unlisted code, and codes 0x01, 0x02, 0x04 and 0x81 in program mode change neither array nor the data registers. Busy lasts 1 cycle, and the command register reads back the code.
- R13: While busy is high, writes to every register offset are ignored, including a second command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr, combinational |
| busy | output | 1 | High while a command runs |
| prog_mode | output | 1 | High when commands target the program array |
| fetch_addr | input | 16 | Program-array fetch address |
| fetch_data | output | 8 | Program-array byte at fetch_addr, valid while busy is low |

## Verification
The assertions assume that bus_wr and bus_addr are known at every clock edge once reset is released. They also assume that fetch_data is only used while busy is low, because the program array's single read port serves the running command while busy is high. The stimulus follows these rules. It changes all inputs on the falling clock edge, holds bus_wr for exactly one rising edge per write, and samples fetch_data only after a command has finished. Register writes issued during busy are deliberate: they check that the controller ignores them.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam logic [7:0] CMD_RD_PAGE   = 8'h01;
    localparam logic [7:0] CMD_WR_PAGE   = 8'h02;
    localparam logic [7:0] CMD_VF_PAGE   = 8'h04;
    localparam logic [7:0] CMD_ER_PAGE   = 8'h05;
    localparam logic [7:0] CMD_ER_ALL    = 8'h06;
    localparam logic [7:0] CMD_RD_BYTE   = 8'h81;
    localparam logic [7:0] CMD_WR_BYTE   = 8'h82;
    localparam logic [7:0] CMD_DATA_MODE = 8'h0F;
    localparam logic [7:0] CMD_PROG_MODE = 8'hF0;

    localparam logic [7:0] VERIFY_PASS = 8'h00;
    localparam logic [7:0] VERIFY_FAIL = 8'hFF;
    localparam logic [7:0] ERASED      = 8'hFF;

    typedef enum logic [3:0] {
        OP_IDLE,
        OP_NOP,
        OP_D_RDPG,
        OP_D_WRPG,
        OP_D_VFPG,
        OP_D_ERASE,
        OP_D_RDB,
        OP_D_WRB,
        OP_P_ERASE,
        OP_P_WRB
    } op_e;

    typedef struct packed {
        logic [3:0][7:0] dat;
        logic [7:0]      alo;
        logic [7:0]      ahi;
        logic [7:0]      cmd;
        logic            pmode;
        op_e             op;
        logic [15:0]     base;
        logic [15:0]     cnt;
        logic [15:0]     last;
        logic            miss;
    } ctl_t;

endpackage

// File: rtl/nvm_byte_array.sv
module nvm_byte_array
    import nvm_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    // Power-on content is the erased state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= ERASED;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
    import nvm_pkg::*;
#(
    parameter int unsigned DATA_AW = 12,
    parameter int unsigned PROG_AW = 10
) (
    input  logic [7:0]  code,
    input  logic        pmode,
    input  logic [15:0] addr,
    output op_e         op,
    output logic [15:0] base,
    output logic [15:0] last,
    output logic        pmode_nx
);

    localparam int unsigned DATA_BYTES = 1 << DATA_AW;
    localparam int unsigned PROG_BYTES = 1 << PROG_AW;
    localparam int unsigned PAGE_AW    = DATA_AW - 2;
    localparam int unsigned BLK_LAST   = 63;

    logic [15:0] dpage_base;
    logic [15:0] dbyte;
    logic [15:0] pblk_base;
    logic        p_in_range;

    always_comb begin
        dpage_base                = '0;
        dpage_base[DATA_AW-1:0]   = {addr[PAGE_AW-1:0], 2'b00};
        dbyte                     = '0;
        dbyte[DATA_AW-1:0]        = addr[DATA_AW-1:0];
        pblk_base                 = {addr[15:6], 6'b000000};
        p_in_range                = (addr >> PROG_AW) == 16'd0;

        op       = OP_NOP;
        base     = '0;
        last     = '0;
        pmode_nx = pmode;

        if (code == CMD_PROG_MODE) begin
            pmode_nx = 1'b1;
        end else if (code == CMD_DATA_MODE) begin
            pmode_nx = 1'b0;
        end else if (!pmode) begin
            case (code)
                CMD_RD_PAGE: begin op = OP_D_RDPG;  base = dpage_base; last = 16'd3; end
                CMD_WR_PAGE: begin op = OP_D_WRPG;  base = dpage_base; last = 16'd3; end
                CMD_VF_PAGE: begin op = OP_D_VFPG;  base = dpage_base; last = 16'd3; end
                CMD_ER_PAGE: begin op = OP_D_ERASE; base = dpage_base; last = 16'd3; end
                CMD_ER_ALL:  begin op = OP_D_ERASE; base = '0; last = 16'(DATA_BYTES - 1); end
                CMD_RD_BYTE: begin op = OP_D_RDB;   base = dbyte; end
                CMD_WR_BYTE: begin op = OP_D_WRB;   base = dbyte; end
                default: ;
            endcase
        end else begin
            case (code)
                CMD_ER_PAGE: begin
                    if (p_in_range) begin
                        op = OP_P_ERASE; base = pblk_base; last = 16'(BLK_LAST);
                    end
                end
                CMD_ER_ALL: begin
                    op = OP_P_ERASE; base = '0; last = 16'(PROG_BYTES - 1);
                end
                CMD_WR_BYTE: begin
                    if (p_in_range) begin
                        op = OP_P_WRB; base = addr;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_pkg::*;
#(
    parameter int unsigned DATA_AW = 12,
    parameter int unsigned PROG_AW = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        busy,
    output logic        prog_mode,
    input  logic [15:0] fetch_addr,
    output logic [7:0]  fetch_data
);

    ctl_t q, d;

    op_e         dec_op;
    logic [15:0] dec_base;
    logic [15:0] dec_last;
    logic        dec_pmode;

    logic [15:0]        cur;
    logic [1:0]         lane;
    logic [7:0]         lane_byte;
    logic               mism;

    logic               dmem_we;
    logic [7:0]         dmem_wdata;
    logic [7:0]         dmem_rdata;
    logic               pmem_we;
    logic [7:0]         pmem_wdata;
    logic [7:0]         pmem_rdata;
    logic [PROG_AW-1:0] pmem_raddr;

    nvm_cmd_decode #(
        .DATA_AW (DATA_AW),
        .PROG_AW (PROG_AW)
    ) u_decode (
        .code     (bus_wdata),
        .pmode    (q.pmode),
        .addr     ({q.ahi, q.alo}),
        .op       (dec_op),
        .base     (dec_base),
        .last     (dec_last),
        .pmode_nx (dec_pmode)
    );

    nvm_byte_array #(.AW(DATA_AW)) u_data_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dmem_we),
        .waddr (cur[DATA_AW-1:0]),
        .wdata (dmem_wdata),
        .raddr (cur[DATA_AW-1:0]),
        .rdata (dmem_rdata)
    );

    nvm_byte_array #(.AW(PROG_AW)) u_prog_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pmem_we),
        .waddr (cur[PROG_AW-1:0]),
        .wdata (pmem_wdata),
        .raddr (pmem_raddr),
        .rdata (pmem_rdata)
    );

    assign busy       = (q.op != OP_IDLE);
    assign prog_mode  = q.pmode;
    assign pmem_raddr = busy ? cur[PROG_AW-1:0] : fetch_addr[PROG_AW-1:0];
    assign fetch_data = ((fetch_addr >> PROG_AW) == 16'd0) ? pmem_rdata : ERASED;

    always_comb begin
        case (bus_addr)
            3'd0:    bus_rdata = q.dat[0];
            3'd1:    bus_rdata = q.dat[1];
            3'd2:    bus_rdata = q.dat[2];
            3'd3:    bus_rdata = q.dat[3];
            3'd4:    bus_rdata = q.alo;
            3'd5:    bus_rdata = q.ahi;
            3'd6:    bus_rdata = q.cmd;
            default: bus_rdata = 8'h00;
        endcase
    end

    always_comb begin
        d          = q;
        cur        = q.base + q.cnt;
        lane       = q.cnt[1:0];
        lane_byte  = q.dat[lane];
        mism       = 1'b0;
        dmem_we    = 1'b0;
        dmem_wdata = ERASED;
        pmem_we    = 1'b0;
        pmem_wdata = ERASED;

        // One array byte per cycle for the running command.
        case (q.op)
            OP_D_RDPG:  d.dat[lane] = dmem_rdata;
            OP_D_WRPG:  begin dmem_we = 1'b1; dmem_wdata = dmem_rdata & lane_byte; end
            OP_D_VFPG:  mism = (dmem_rdata != lane_byte);
            OP_D_ERASE: dmem_we = 1'b1;
            OP_D_RDB:   d.dat[0] = dmem_rdata;
            OP_D_WRB:   begin dmem_we = 1'b1; dmem_wdata = dmem_rdata & q.dat[0]; end
            OP_P_ERASE: pmem_we = 1'b1;
            OP_P_WRB:   begin pmem_we = 1'b1; pmem_wdata = pmem_rdata & q.dat[0]; end
            default: ;
        endcase

        if (q.op != OP_IDLE) begin
            d.miss = q.miss | mism;
            if (q.cnt == q.last) begin
                d.op  = OP_IDLE;
                d.cnt = '0;
                if (q.op == OP_D_VFPG) begin
                    d.cmd = (q.miss | mism) ? VERIFY_FAIL : VERIFY_PASS;
                end
            end else begin
                d.cnt = q.cnt + 16'd1;
            end
        end else if (bus_wr) begin
            case (bus_addr)
                3'd0, 3'd1, 3'd2, 3'd3: d.dat[bus_addr[1:0]] = bus_wdata;
                3'd4: d.alo = bus_wdata;
                3'd5: d.ahi = bus_wdata;
                3'd6: begin
                    d.cmd   = bus_wdata;
                    d.op    = dec_op;
                    d.base  = dec_base;
                    d.last  = dec_last;
                    d.cnt   = '0;
                    d.miss  = 1'b0;
                    d.pmode = dec_pmode;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.cmd <= CMD_RD_PAGE;
            q.op  <= OP_IDLE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk
    import nvm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic       busy,
    input logic       prog_mode,
    input ctl_t       q,
    input logic       dmem_we,
    input logic [7:0] dmem_wdata,
    input logic [7:0] dmem_rdata,
    input logic       pmem_we
);

    // R1: first edge out of reset sees the power-on command value
    a_r1_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q.cmd == CMD_RD_PAGE && !busy && !prog_mode));

    // R13: address registers hold while a command runs
    a_r13_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(q.alo) && $stable(q.ahi)));

    // R13: an accepted command write always raises busy
    a_r13_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && bus_addr == 3'd6) |=> busy);

    // R9: mode only moves on an accepted command write
    a_r9_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode != $past(prog_mode)) |-> $past(!busy && bus_wr && bus_addr == 3'd6));

    // R12: no-op commands never write an array
    a_r12_nop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.op == OP_NOP) |-> !(dmem_we || pmem_we));

    // R7: verify never writes
    a_r7_verify_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op == OP_D_VFPG) |-> !dmem_we);

    // R5: programming only clears bits
    a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we && (q.op == OP_D_WRPG || q.op == OP_D_WRB)) |->
        ((dmem_wdata & ~dmem_rdata) == 8'h00));

endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .busy       (busy),
    .prog_mode  (prog_mode),
    .q          (q),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .pmem_we    (pmem_we)
);

// File: tb/nvm_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl_bench;

    localparam int DATA_AW = 12;
    localparam int PROG_AW = 8;
    localparam int DBYTES  = 1 << DATA_AW;
    localparam int PBYTES  = 1 << PROG_AW;
    localparam int DPAGES  = DBYTES / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        busy;
    logic        prog_mode;
    logic [15:0] fetch_addr = 16'h0000;
    logic [7:0]  fetch_data;

    int checks = 0;
    int failures = 0;
    int busy_seen = 0;
    bit finished = 0;

    logic [7:0] dm [DBYTES];
    logic [7:0] pm [PBYTES];

    always #4 clk = ~clk;

    always @(negedge clk) if (busy === 1'b1) busy_seen++;

    nvm_cmd_ctrl #(.DATA_AW(DATA_AW), .PROG_AW(PROG_AW)) u_nvm_cmd_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .prog_mode  (prog_mode),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_addr(input logic [15:0] a);
        wr_reg(3'd4, a[7:0]);
        wr_reg(3'd5, a[15:8]);
    endtask

    task automatic do_cmd(input logic [7:0] code, input int len, input string req);
        busy_seen = 0;
        wr_reg(3'd6, code);
        while (busy === 1'b1) @(negedge clk);
        chk({req, " busy cycles"}, busy_seen, len);
    endtask

    task automatic set_dat(input logic [31:0] w);
        for (int k = 0; k < 4; k++) wr_reg(3'(k), w[8*k +: 8]);
    endtask

    task automatic get_dat(output logic [31:0] w);
        logic [7:0] v;
        for (int k = 0; k < 4; k++) begin
            rd_reg(3'(k), v);
            w[8*k +: 8] = v;
        end
    endtask

    task automatic check_page(input int p, input string req);
        logic [31:0] w;
        set_addr(16'(p));
        do_cmd(8'h01, 4, req);
        get_dat(w);
        chk(req, w, {dm[4*p+3], dm[4*p+2], dm[4*p+1], dm[4*p]});
    endtask

    task automatic dump_data(input string req);
        for (int p = 0; p < DPAGES; p++) check_page(p, req);
    endtask

    task automatic sweep_fetch(input string req);
        for (int a = 0; a < PBYTES; a++) begin
            fetch_addr = 16'(a);
            #1;
            chk(req, fetch_data, pm[a]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [31:0] w;
        for (int i = 0; i < DBYTES; i++) dm[i] = 8'hFF;
        for (int i = 0; i < PBYTES; i++) pm[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: power-on state
        rd_reg(3'd6, v); chk("R1 cmd", v, 8'h01);
        for (int k = 0; k < 6; k++) begin
            rd_reg(3'(k), v); chk("R1 reg", v, 8'h00);
        end
        chk("R1 busy", busy, 1'b0);
        chk("R1 prog_mode", prog_mode, 1'b0);
        sweep_fetch("R1 prog array");
        dump_data("R1 data array");

        // R2: register window read-back
        for (int k = 0; k < 6; k++) wr_reg(3'(k), 8'(8'h11 * (k + 1)));
        for (int k = 0; k < 6; k++) begin
            rd_reg(3'(k), v); chk("R2 readback", v, 8'(8'h11 * (k + 1)));
        end
        rd_reg(3'd7, v); chk("R2 offset7", v, 8'h00);

        // R3: byte programming, two passes to see AND behaviour
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 48; i++) begin
                int a;
                logic [7:0] dv;
                a  = (i * 67 + 5) % DBYTES;
                dv = (pass == 0) ? 8'((i * 37) ^ 8'h5A) : 8'(i * 91 + 3);
                wr_reg(3'd0, dv);
                set_addr(16'(a) | 16'hF000);
                do_cmd(8'h82, 1, "R3");
                dm[a] = dm[a] & dv;
            end
        end

        // R4: byte reads
        for (int i = 0; i < 48; i++) begin
            int a;
            a = (i * 67 + 5) % DBYTES;
            set_addr(16'(a));
            do_cmd(8'h81, 1, "R4");
            rd_reg(3'd0, v);
            chk("R4 byte", v, dm[a]);
        end

        // R5: page programming with junk in the upper address bits
        for (int k = 0; k < 16; k++) begin
            int p;
            p = (k * 131 + 7) % DPAGES;
            w = {8'(k * 13), 8'(p ^ 8'hA5), 8'(k + 8'h30), 8'(~k)};
            set_dat(w);
            set_addr(16'(p) | 16'hA800);
            do_cmd(8'h02, 4, "R5");
            for (int j = 0; j < 4; j++) dm[4*p+j] = dm[4*p+j] & w[8*j +: 8];
        end

        // R6: page reads of the programmed pages
        for (int k = 0; k < 16; k++) check_page((k * 131 + 7) % DPAGES, "R6");

        // R7: verify pass and fail
        begin
            int p;
            p = 138;
            w = {dm[4*p+3], dm[4*p+2], dm[4*p+1], dm[4*p]};
            set_dat(w);
            set_addr(16'(p));
            do_cmd(8'h04, 4, "R7");
            rd_reg(3'd6, v); chk("R7 match", v, 8'h00);
            set_dat(w ^ 32'h0100_0000);
            do_cmd(8'h04, 4, "R7");
            rd_reg(3'd6, v); chk("R7 mismatch last byte", v, 8'hFF);
            set_dat(w ^ 32'h0000_0001);
            do_cmd(8'h04, 4, "R7");
            rd_reg(3'd6, v); chk("R7 mismatch first byte", v, 8'hFF);
            set_dat(w);
            do_cmd(8'h04, 4, "R7");
            rd_reg(3'd6, v); chk("R7 match again", v, 8'h00);
        end

        // R8: page erase, then whole-array check, then erase all
        set_addr(16'd138);
        do_cmd(8'h05, 4, "R8");
        for (int j = 0; j < 4; j++) dm[4*138+j] = 8'hFF;
        dump_data("R8 before erase-all");
        do_cmd(8'h06, DBYTES, "R8");
        for (int i = 0; i < DBYTES; i++) dm[i] = 8'hFF;
        for (int p = 0; p < DPAGES; p += 97) check_page(p, "R8 erased");

        // R13: writes during busy are ignored
        set_dat(32'hA3A2A1A0);
        set_addr(16'h0123);
        busy_seen = 0;
        wr_reg(3'd6, 8'h06);
        wr_reg(3'd0, 8'h55);
        wr_reg(3'd4, 8'h77);
        wr_reg(3'd5, 8'h01);
        wr_reg(3'd6, 8'h82);
        while (busy === 1'b1) @(negedge clk);
        chk("R13 busy cycles", busy_seen, DBYTES);
        rd_reg(3'd0, v); chk("R13 data1", v, 8'hA0);
        rd_reg(3'd4, v); chk("R13 addr low", v, 8'h23);
        rd_reg(3'd5, v); chk("R13 addr high", v, 8'h01);
        rd_reg(3'd6, v); chk("R13 cmd", v, 8'h06);
        @(negedge clk);
        chk("R13 no second command", busy, 1'b0);

        // R9: enter program mode
        do_cmd(8'hF0, 1, "R9");
        chk("R9 prog_mode set", prog_mode, 1'b1);

        // R10: program-array byte writes, two passes
        for (int a = 0; a < PBYTES; a++) begin
            wr_reg(3'd0, 8'(a * 29 + 7));
            set_addr(16'(a));
            do_cmd(8'h82, 1, "R10");
            pm[a] = pm[a] & 8'(a * 29 + 7);
        end
        for (int a = 0; a < PBYTES; a += 3) begin
            wr_reg(3'd0, 8'(a ^ 8'hC3));
            set_addr(16'(a));
            do_cmd(8'h82, 1, "R10");
            pm[a] = pm[a] & 8'(a ^ 8'hC3);
        end
        wr_reg(3'd0, 8'h00);
        set_addr(16'(PBYTES));
        do_cmd(8'h82, 1, "R10 beyond array");
        set_addr(16'hDFFF);
        do_cmd(8'h82, 1, "R10 top of range");
        sweep_fetch("R10 fetch");
        fetch_addr = 16'(PBYTES + 5); #1;
        chk("R10 fetch beyond array", fetch_data, 8'hFF);

        // R11: 64-byte block erase, out-of-range erase, erase all
        set_addr(16'h0085);
        do_cmd(8'h05, 64, "R11");
        for (int a = 16'h80; a < 16'hC0; a++) pm[a] = 8'hFF;
        sweep_fetch("R11 block");
        set_addr(16'(PBYTES + 64));
        do_cmd(8'h05, 1, "R11 beyond array");
        sweep_fetch("R11 beyond array");
        do_cmd(8'h06, PBYTES, "R11");
        for (int a = 0; a < PBYTES; a++) pm[a] = 8'hFF;
        sweep_fetch("R11 all");

        // R12: no-op codes in program mode
        set_dat(32'h00B2B1B0);
        set_addr(16'h0004);
        begin
            logic [7:0] codes [6];
            codes = '{8'h01, 8'h02, 8'h04, 8'h81, 8'h03, 8'h5A};
            for (int i = 0; i < 6; i++) begin
                do_cmd(codes[i], 1, "R12 prog mode");
                rd_reg(3'd6, v); chk("R12 cmd readback", v, codes[i]);
                get_dat(w); chk("R12 data regs", w, 32'h00B2B1B0);
            end
        end
        sweep_fetch("R12 prog array");

        // R9: back to data mode
        do_cmd(8'h0F, 1, "R9");
        chk("R9 prog_mode clear", prog_mode, 1'b0);

        // R12: no-op codes in data mode
        set_dat(32'h00000000);
        set_addr(16'h0010);
        do_cmd(8'h03, 1, "R12 data mode");
        rd_reg(3'd6, v); chk("R12 reserved readback", v, 8'h03);
        do_cmd(8'h5A, 1, "R12 data mode");
        get_dat(w); chk("R12 data regs", w, 32'h0);
        dump_data("R12 data array");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule